// File: doc/BRIEF.md
# I2C Pin Timing Conditioner

This block sits between the raw open-drain SCL and SDA pad levels and an internal I2C engine. On the receive side, each line passes through a two-flop synchroniser and then a glitch filter. The filter drops any pulse that does not outlast a programmable number of 10 ns ticks. The filtered SDA then passes through a programmable hold stage, counted in 50 ns ticks. This gives the engine extra internal hold time on SDA relative to SCL.

On the drive side, the engine presents the SDA output-enable value it wants. Each falling edge of the filtered SCL opens a timing window. While the window is open, the pad enable is frozen. When the window closes, the enable takes the engine's value. The window length is a fixed base of seven 50 ns ticks plus a 2-bit code. This gives SCL-to-SDA delays of 350, 400, 450 or 500 ns. Outside a window, the enable follows the engine one clock later, so START and STOP conditions pass straight through. Every setting is sampled when the transition it times begins, so a change made mid-flight affects only later transitions.

Top module: `i2c_pin_cond`

## Requirements
- R1: While reset is asserted and directly after it, `scl_filt` and `sda_filt` read 1 and `sda_oe` reads 0.
- R2: A level change on `scl_raw` or `sda_raw` reaches the filtered output only if it lasts at least `cfg_filt_depth`+1 counted `tick10` pulses. With `tick10` high every clock, a pulse of `cfg_filt_depth` clocks or fewer never appears at the output, and a pulse of `cfg_filt_depth`+1 clocks does.
- R3: With `cfg_filt_depth` = 0, a change is passed after synchronisation plus one counted `tick10`. A one-clock pulse therefore appears at the output.
- R4: With `tick10` high every clock, a change on `scl_raw` made between two rising edges shows on `scl_filt` right after the (`cfg_filt_depth`+4)-th following rising edge. This latency is not affected by `cfg_sda_hold`.
- R5: `sda_filt` follows the filtered SDA after `cfg_sda_hold` counted `tick50` pulses. With a hold of 0 it lines up with the SCL path, giving the R4 latency. With a hold of h ≥ 1 and `tick50` every fifth clock, the step latency lies in [depth+4+5(h−1), depth+3+5h] rising edges.
- R6: A falling edge of `scl_filt` opens a window of 7+`cfg_sda_odly` counted `tick50` pulses. This is 350/400/450/500 ns for codes 0/1/2/3. At the end of the window, `sda_oe` takes `sda_oe_req`. With `tick50` every fifth clock, the change lands within [5N−3, 5N+1] rising edges after the falling edge, where N is 7+code.
- R7: While a window is open, `sda_oe` does not change, whatever `sda_oe_req` does.
- R8: With no window open and no SCL fall, `sda_oe` equals the value `sda_oe_req` had at the previous rising edge.
- R9: A transition already being timed uses the filter depth and output-delay code it started with. New settings apply from the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick10 | input | 1 | One-clock pulse every 10 ns |
| tick50 | input | 1 | One-clock pulse every 50 ns |
| scl_raw | input | 1 | Raw SCL pad level |
| sda_raw | input | 1 | Raw SDA pad level |
| cfg_filt_depth | input | 4 | Glitch reject width, in 10 ns ticks |
| cfg_sda_hold | input | 3 | Extra SDA input hold, in 50 ns ticks |
| cfg_sda_odly | input | 2 | SCL-fall-to-SDA-drive code, 350 ns plus 50 ns per step |
| sda_oe_req | input | 1 | SDA pull-down request from the engine |
| scl_filt | output | 1 | Filtered and aligned SCL |
| sda_filt | output | 1 | Filtered SDA with hold delay |
| sda_oe | output | 1 | Timed SDA pull-down enable to the pad |

## Verification
The assertions assume that `tick10` and `tick50` are single-clock pulses driven away from the sampling edge. They also assume that the configuration fields are steady at each rising edge. The latency bounds in R5 and R6 further assume that `tick50` recurs every five clocks. The bench generates the ticks from its own phase counter: `tick10` is held high and `tick50` fires once every five clocks. It changes the pads, the configuration and `sda_oe_req` only on falling clock edges. It allows SCL to settle between cases so that no window or filter count is carried over from the previous case.

// File: rtl/i2c_pin_cond_pkg.sv
package i2c_pin_cond_pkg;
  // Ticks a raw level must persist before it is accepted.
  function automatic int filt_limit(input int depth);
    return depth + 1;
  endfunction

  // Length, in 50 ns ticks, of the SCL-fall-to-SDA-drive window.
  function automatic int odly_ticks(input int base, input int code);
    return base + code;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/settle_cnt.sv
module settle_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          din,
  input  logic [CW-1:0] lim_in,
  output logic          dout
);
  logic [CW-1:0] cnt_q, lim_q, lim_eff, cnt_nx;
  logic          out_q;
  logic          mismatch, accept;

  assign lim_eff  = (cnt_q == '0) ? lim_in : lim_q;
  assign cnt_nx   = cnt_q + 1'b1;
  assign mismatch = (din != out_q);
  assign accept   = mismatch && ((lim_eff == '0) || (tick && (cnt_nx == lim_eff)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      out_q <= 1'b1;
    end else begin
      if (cnt_q == '0) lim_q <= lim_in;
      if (!mismatch || accept) cnt_q <= '0;
      else if (tick)           cnt_q <= cnt_nx;
      if (accept) out_q <= din;
    end
  end

  assign dout = out_q;

  AST_OUT_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(din))); // R2
  AST_CNT_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < lim_q)); // R9
endmodule

// File: rtl/sda_out_delay.sv
module sda_out_delay #(
  parameter int ODW   = 2,
  parameter int OBASE = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           scl,
  input  logic           req,
  input  logic [ODW-1:0] code,
  output logic           oe
);
  import i2c_pin_cond_pkg::*;
  localparam int OCW = $clog2(OBASE + (1 << ODW));

  logic [OCW-1:0] cnt_q, lim_q;
  logic           scl_q, timing_q, oe_q;
  logic           fall, expire;

  assign fall   = scl_q && !scl;
  assign expire = timing_q && tick && ((cnt_q + 1'b1) == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      timing_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      scl_q <= scl;
      if (fall) begin
        timing_q <= 1'b1;
        cnt_q    <= '0;
        lim_q    <= OCW'(odly_ticks(OBASE, int'(code)));
      end else if (expire) begin
        timing_q <= 1'b0;
        cnt_q    <= '0;
        oe_q     <= req;
      end else if (timing_q) begin
        if (tick) cnt_q <= cnt_q + 1'b1;
      end else begin
        oe_q <= req;
      end
    end
  end

  assign oe = oe_q;

  AST_OE_FROZEN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_q && !expire) |=> $stable(oe_q)); // R7
  AST_OE_FROZEN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> $stable(oe_q)); // R7
  AST_OE_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_q && !fall) |=> (oe_q == $past(req))); // R8
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    timing_q |-> (cnt_q < lim_q)); // R6
endmodule

// File: rtl/i2c_pin_cond.sv
module i2c_pin_cond #(
  parameter int FDW   = 4,
  parameter int HDW   = 3,
  parameter int ODW   = 2,
  parameter int OBASE = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick10,
  input  logic           tick50,
  input  logic           scl_raw,
  input  logic           sda_raw,
  input  logic [FDW-1:0] cfg_filt_depth,
  input  logic [HDW-1:0] cfg_sda_hold,
  input  logic [ODW-1:0] cfg_sda_odly,
  input  logic           sda_oe_req,
  output logic           scl_filt,
  output logic           sda_filt,
  output logic           sda_oe
);
  import i2c_pin_cond_pkg::*;
  localparam int FCW   = FDW + 1;
  localparam int NLINE = 2;   // index 0: SCL, index 1: SDA

  logic [NLINE-1:0] raw_v, sync_v, glf_v;
  logic [FCW-1:0]   glf_lim;
  logic             scl_align_q;

  assign raw_v   = {sda_raw, scl_raw};
  assign glf_lim = FCW'(filt_limit(int'(cfg_filt_depth)));

  pin_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(sync_v)
  );

  for (genvar i = 0; i < NLINE; i++) begin : g_glf
    settle_cnt #(.CW(FCW)) u_glf (
      .clk(clk), .rst_n(rst_n), .tick(tick10),
      .din(sync_v[i]), .lim_in(glf_lim), .dout(glf_v[i])
    );
  end

  // SDA hold stage; SCL gets one register so a zero hold keeps both aligned.
  settle_cnt #(.CW(HDW)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick50),
    .din(glf_v[1]), .lim_in(cfg_sda_hold), .dout(sda_filt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_align_q <= 1'b1;
    else        scl_align_q <= glf_v[0];
  end
  assign scl_filt = scl_align_q;

  sda_out_delay #(.ODW(ODW), .OBASE(OBASE)) u_odly (
    .clk(clk), .rst_n(rst_n), .tick(tick50), .scl(scl_align_q),
    .req(sda_oe_req), .code(cfg_sda_odly), .oe(sda_oe)
  );

  AST_SCL_FOLLOWS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_align_q) |-> (scl_align_q == $past(glf_v[0]))); // R4
endmodule

// File: tb/tb_i2c_pin_cond.sv
module tb_i2c_pin_cond;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick10 = 1'b1;
  logic scl_raw = 1'b1, sda_raw = 1'b1, sda_oe_req = 1'b0;
  logic [3:0] cfg_filt_depth = '0;
  logic [2:0] cfg_sda_hold = '0;
  logic [1:0] cfg_sda_odly = '0;
  logic scl_filt, sda_filt, sda_oe;
  int ph = 0;
  int n_chk = 0, n_fail = 0;
  logic tick50;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) ph <= (ph == 4) ? 0 : ph + 1;
  assign tick50 = (ph == 0);

  i2c_pin_cond dut (
    .clk(clk), .rst_n(rst_n), .tick10(tick10), .tick50(tick50),
    .scl_raw(scl_raw), .sda_raw(sda_raw), .cfg_filt_depth(cfg_filt_depth),
    .cfg_sda_hold(cfg_sda_hold), .cfg_sda_odly(cfg_sda_odly),
    .sda_oe_req(sda_oe_req), .scl_filt(scl_filt), .sda_filt(sda_filt), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic probe(input int sel);
    return (sel == 0) ? scl_filt : (sel == 1) ? sda_filt : sda_oe;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Rising edges until the selected output differs from its current value.
  task automatic meas(input int sel, output int n);
    logic old;
    old = probe(sel);
    n = -1;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (probe(sel) != old) begin
        n = k;
        break;
      end
    end
  endtask

  // Low pulse of w clocks on a raw line; returns 1 if the output ever went low.
  task automatic pulse(input int sel, input int w, output bit seen);
    seen = 0;
    if (sel == 0) scl_raw = 1'b0; else sda_raw = 1'b0;
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      if (probe(sel) == 1'b0) seen = 1;
    end
    if (sel == 0) scl_raw = 1'b1; else sda_raw = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (probe(sel) == 1'b0) seen = 1;
    end
  endtask

  task automatic wait_scl_low();
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (scl_filt == 1'b0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d_meas;
    bit seen;
    cycles(3);
    chk(scl_filt == 1 && sda_filt == 1 && sda_oe == 0, "R1 in reset",
        {scl_filt, sda_filt, sda_oe}, 3'b110);
    rst_n = 1'b1;
    cycles(2);
    chk(scl_filt == 1 && sda_filt == 1 && sda_oe == 0, "R1 after reset",
        {scl_filt, sda_filt, sda_oe}, 3'b110);

    // R4: SCL step latency over every depth, hold at maximum.
    cfg_sda_hold = 3'd7;
    for (int d = 0; d < 16; d++) begin
      cfg_filt_depth = 4'(d);
      scl_raw = 1'b0;
      meas(0, d_meas);
      chk(d_meas == d + 4, "R4 scl fall latency", d_meas, d + 4);
      scl_raw = 1'b1;
      meas(0, d_meas);
      chk(d_meas == d + 4, "R4 scl rise latency", d_meas, d + 4);
      cycles(4);
    end
    cfg_sda_hold = 3'd0;

    // R2 / R3: pulse rejection at the boundary, both lines.
    for (int d = 0; d < 16; d++) begin
      cfg_filt_depth = 4'(d);
      if (d > 0) begin
        pulse(0, d, seen);
        chk(!seen, "R2 scl short pulse dropped", seen, 0);
      end
      pulse(0, d + 1, seen);
      chk(seen, (d == 0) ? "R3 depth0 one-clock pulse" : "R2 scl pulse passes", seen, 1);
    end
    for (int d = 1; d < 16; d += 3) begin
      cfg_filt_depth = 4'(d);
      pulse(1, d, seen);
      chk(!seen, "R2 sda short pulse dropped", seen, 0);
      pulse(1, d + 1, seen);
      chk(seen, "R2 sda pulse passes", seen, 1);
    end

    // R5: SDA hold sweep, depth 2.
    cfg_filt_depth = 4'd2;
    for (int h = 0; h < 8; h++) begin
      cfg_sda_hold = 3'(h);
      sda_raw = 1'b0;
      meas(1, d_meas);
      if (h == 0) chk(d_meas == 6, "R5 hold0 aligned", d_meas, 6);
      else chk(d_meas >= 6 + 5*(h-1) && d_meas <= 5 + 5*h, "R5 hold window", d_meas, 5 + 5*h);
      sda_raw = 1'b1;
      meas(1, d_meas);
      if (h == 0) chk(d_meas == 6, "R5 hold0 aligned rise", d_meas, 6);
      else chk(d_meas >= 6 + 5*(h-1) && d_meas <= 5 + 5*h, "R5 hold window rise", d_meas, 5 + 5*h);
      cycles(3);
    end
    cfg_sda_hold = 3'd0;
    cfg_filt_depth = 4'd0;

    // R8: idle follow.
    sda_oe_req = 1'b1;
    @(negedge clk);
    chk(sda_oe == 1, "R8 idle follow high", sda_oe, 1);
    sda_oe_req = 1'b0;
    @(negedge clk);
    chk(sda_oe == 0, "R8 idle follow low", sda_oe, 0);

    // R6: window length per code.
    for (int c = 0; c < 4; c++) begin
      int nt;
      nt = 7 + c;
      cfg_sda_odly = 2'(c);
      scl_raw = 1'b0;
      wait_scl_low();
      sda_oe_req = ~sda_oe;
      meas(2, d_meas);
      chk(d_meas >= 5*nt - 3 && d_meas <= 5*nt + 1, "R6 scl-to-sda delay", d_meas, 5*nt);
      scl_raw = 1'b1;
      cycles(8);
    end

    // R7: request toggling inside the window does not reach the pin.
    cfg_sda_odly = 2'd0;
    sda_oe_req = 1'b0;
    cycles(2);
    scl_raw = 1'b0;
    wait_scl_low();
    sda_oe_req = 1'b1;
    cycles(4);
    sda_oe_req = 1'b0;
    cycles(4);
    sda_oe_req = 1'b1;
    cycles(31 - 8);
    chk(sda_oe == 0, "R7 frozen in window", sda_oe, 0);
    cycles(5);
    chk(sda_oe == 1, "R7 applied at window end", sda_oe, 1);
    scl_raw = 1'b1;
    cycles(8);

    // R9: output-delay code changed mid-window keeps the old length.
    cfg_sda_odly = 2'd0;
    scl_raw = 1'b0;
    wait_scl_low();
    sda_oe_req = 1'b0;
    @(negedge clk);
    cfg_sda_odly = 2'd3;
    meas(2, d_meas);
    d_meas = d_meas + 1;
    chk(d_meas >= 32 && d_meas <= 36, "R9 odly old code kept", d_meas, 34);
    scl_raw = 1'b1;
    cycles(8);

    // R9: filter depth changed after counting began keeps the old depth.
    cfg_filt_depth = 4'd6;
    scl_raw = 1'b0;
    cycles(4);
    cfg_filt_depth = 4'd0;
    meas(0, d_meas);
    d_meas = d_meas + 4;
    chk(d_meas == 10, "R9 filter old depth kept", d_meas, 10);
    scl_raw = 1'b1;
    cycles(8);
    // R9: new depth applies to the next transition.
    scl_raw = 1'b0;
    meas(0, d_meas);
    chk(d_meas == 4, "R9 new depth next edge", d_meas, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule